// File: doc/BRIEF.md
# Two-Wire Serial Memory Target with Address-Counter Reads

This block is a two-wire (I2C) target that sits in front of a 4096-byte storage array. The block samples the clock and data lines with the system clock, and finds START, repeated START and STOP conditions. It compares the select byte with its own address and moves through the address, write and read phases of a transfer. Read data leaves most significant bit first through an open-drain pull-down enable. The bus master pulls the line high.

A single address counter persists from one transaction to the next. A read that carries no address continues from the location after the last one touched. A dummy write that carries only a word address moves the counter, so a following repeated START with a read begins at that word. While the master keeps acknowledging, the block streams consecutive bytes and wraps from the top of the array back to zero. A minimal one-byte write path exists, together with a preload port, so that test code can fill the array directly.

Top module: `serial_mem_target`

## Requirements
- R1: After reset the data-line pull-down enable `sda_oe` is 0 and the address counter is 0, so the first read with no address returns location 0.
- R2: The select byte is bits 7..4 = 1010, bits 3..1 = `strap_i`, bit 0 = direction (1 read, 0 write). On a match the block pulls SDA low in the ninth clock. On a mismatch it acknowledges nothing and keeps SDA released until the next START or STOP.
- R3: `sda_oe` changes only while SCL is low. It is 0 during the acknowledge bit that the master returns after each data byte.
- R4: In a read with no address, the block acknowledges the select byte and then sends the byte at the counter, MSB first, with `sda_oe`=1 for each 0 bit.
- R5: A write-direction transfer carries a two-byte word address, high byte first. Only the low 12 bits are used. Both address bytes are acknowledged. After a repeated START and a read select, data starts at that address.
- R6: A master ACK (SDA low) after a data byte makes the block send the next byte from the address plus one. A NACK followed by STOP ends the read.
- R7: The counter wraps from 4095 to 0 during reads and keeps sending data.
- R8: After any read of location n, the next read with no address returns location n+1.
- R9: A write of select, two address bytes and one data byte stores the byte and leaves the counter at the address plus one.
- R10: A START or STOP inside a byte abandons the transfer. The counter keeps its previous value, and no partial byte is written.
- R11: While `bd_we` is high, the byte `bd_data` is written to location `bd_addr` on each clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Board-strapped low bits of the target address |
| bd_we | input | 1 | Preload write strobe |
| bd_addr | input | 12 | Preload write location |
| bd_data | input | 8 | Preload write byte |

## Verification
The hardest situations to reach are the ones that depend on history: a START or STOP arriving in the middle of a byte, and the counter crossing the top of the array inside one burst. The bench plays the master bit by bit. It cuts an address byte short with a repeated START, and it cuts a data byte short with a STOP. Each time, it then issues a read with no address, which shows whether the counter moved. It aims a dummy write at location 4094 and acknowledges three bytes, so that locations 4095, 0 and 1 follow in one burst.

// File: rtl/serial_mem_pkg.sv
// Shared definitions for the serial memory target.
// Assumes a single clock domain for everything that imports it.
package serial_mem_pkg;

    // Protocol phases of the target state machine
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_ACK_DEV,
        ST_ADDR_HI,
        ST_ACK_AH,
        ST_ADDR_LO,
        ST_ACK_AL,
        ST_WDATA,
        ST_ACK_WD,
        ST_TX,
        ST_RACK,
        ST_IGNORE
    } tgt_state_t;

    // Fixed device-type nibble of the select byte
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/serial_mem_sampler.sv
// Bus line sampler: brings SCL/SDA into the clk domain and flags
// clock edges, START and STOP. Assumes clk runs several times
// faster than SCL and SYNC_STAGES >= 2. Lines reset to the idle (high) level.
module serial_mem_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_s;
    logic                   scl_d;
    logic                   sda_d;

    // Synchronizer chains plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    // Event decode from the current and previous sampled levels
    always_comb begin
        scl_s     = scl_sync[SYNC_STAGES-1];
        sda_s     = sda_sync[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_evt = scl_s & scl_d & sda_d & ~sda_s;
        stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/serial_mem_array.sv
// Byte storage with one write port and one registered read port.
// Contents are not reset. A read of a location written in the same
// cycle returns the old value.
module serial_mem_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write port
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read port, follows raddr every cycle
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/serial_mem_ctrl.sv
// Protocol engine: receives the select and address bytes, runs the
// single-byte write and the counter-driven reads, and drives the
// open-drain enable. Assumes rd_data reflects the array at addr_ctr
// within a few clocks (many clocks pass between SCL edges). ADDR_W
// must lie between 9 and 16.
module serial_mem_ctrl
    import serial_mem_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_evt,
    input  logic               stop_evt,
    input  logic [2:0]         strap,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic [ADDR_W-1:0]  addr_ctr,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               sda_oe,
    output tgt_state_t         state
);

    localparam int HI_W = ADDR_W - BYTE_W;

    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [HI_W-1:0]   addr_hi;
    logic              rw_q;
    logic              mack;
    logic              byte_full;
    logic              sel_match;

    // Byte-complete and select-match decode
    always_comb begin
        byte_full = (bit_cnt == 4'd8);
        sel_match = (shreg[7:4] == DEV_TYPE) && (shreg[3:1] == strap);
    end

    // Main protocol sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sda_oe   <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            addr_hi  <= '0;
            addr_ctr <= '0;
            rw_q     <= 1'b0;
            mack     <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_evt) begin
                state   <= ST_DEVSEL;
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end else if (stop_evt) begin
                state   <= ST_IDLE;
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
            end else begin
                case (state)
                    ST_DEVSEL, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA: begin
                        if (scl_rise && !byte_full) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && byte_full) begin
                            bit_cnt <= '0;
                            sda_oe  <= 1'b1;
                            case (state)
                                ST_DEVSEL: begin
                                    if (sel_match) begin
                                        rw_q  <= shreg[0];
                                        state <= ST_ACK_DEV;
                                    end else begin
                                        sda_oe <= 1'b0;
                                        state  <= ST_IGNORE;
                                    end
                                end
                                ST_ADDR_HI: begin
                                    addr_hi <= shreg[HI_W-1:0];
                                    state   <= ST_ACK_AH;
                                end
                                ST_ADDR_LO: begin
                                    addr_ctr <= {addr_hi, shreg};
                                    state    <= ST_ACK_AL;
                                end
                                default: begin
                                    wr_en    <= 1'b1;
                                    wr_addr  <= addr_ctr;
                                    wr_data  <= shreg;
                                    addr_ctr <= addr_ctr + 1'b1;
                                    state    <= ST_ACK_WD;
                                end
                            endcase
                        end
                    end
                    ST_ACK_DEV: begin
                        if (scl_fall) begin
                            if (rw_q) begin
                                shreg    <= rd_data;
                                sda_oe   <= ~rd_data[BYTE_W-1];
                                addr_ctr <= addr_ctr + 1'b1;
                                bit_cnt  <= '0;
                                state    <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_ADDR_HI;
                            end
                        end
                    end
                    ST_ACK_AH: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_ADDR_LO;
                        end
                    end
                    ST_ACK_AL: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                    ST_ACK_WD: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_IGNORE;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe  <= ~shreg[BYTE_W-2];
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                shreg    <= rd_data;
                                sda_oe   <= ~rd_data[BYTE_W-1];
                                addr_ctr <= addr_ctr + 1'b1;
                                bit_cnt  <= '0;
                                state    <= ST_TX;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/serial_mem_target.sv
// Top level of the serial memory target. Ties the line sampler, the
// protocol engine and the storage array together. The preload port
// takes priority over the protocol write on the single write port.
// Assumes clk is at least 8x the SCL rate.
module serial_mem_target
    import serial_mem_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        strap_i,
    input  logic              bd_we,
    input  logic [ADDR_W-1:0] bd_addr,
    input  logic [7:0]        bd_data
);

    logic              sda_s;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_evt;
    logic              stop_evt;
    logic [ADDR_W-1:0] addr_ctr;
    logic              fsm_we;
    logic [ADDR_W-1:0] fsm_waddr;
    logic [7:0]        fsm_wdata;
    logic [7:0]        rd_data;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    tgt_state_t        fsm_state;

    serial_mem_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    serial_mem_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .strap     (strap_i),
        .rd_data   (rd_data),
        .addr_ctr  (addr_ctr),
        .wr_en     (fsm_we),
        .wr_addr   (fsm_waddr),
        .wr_data   (fsm_wdata),
        .sda_oe    (sda_oe),
        .state     (fsm_state)
    );

    // Write-port arbitration, preload first
    always_comb begin
        mem_we    = bd_we | fsm_we;
        mem_waddr = bd_we ? bd_addr : fsm_waddr;
        mem_wdata = bd_we ? bd_data : fsm_wdata;
    end

    serial_mem_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (8)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (addr_ctr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/serial_mem_target_chk.sv
// Property checker for serial_mem_target, attached by bind below.
// Observes top-level ports and the sampler/engine handoff signals.
module serial_mem_target_chk
    import serial_mem_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              start_evt,
    input logic              stop_evt,
    input logic [ADDR_W-1:0] addr_ctr,
    input tgt_state_t        fsm_state
);

    // R1
    reset_release_chk: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && addr_ctr == '0));

    // R3
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R3
    master_ack_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_RACK) |-> !sda_oe);

    // R2
    unselected_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_IGNORE || fsm_state == ST_IDLE) |-> !sda_oe);

    // R10
    abort_keeps_ctr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt || stop_evt) |=> $stable(addr_ctr));

endmodule

bind serial_mem_target serial_mem_target_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .addr_ctr  (addr_ctr),
    .fsm_state (fsm_state)
);

// File: tb/tb_serial_mem_target.sv
// Bench for serial_mem_target: plays the bus master bit by bit and keeps
// a behavioural model (array plus counter) that predicts every byte
// and every acknowledge. The pull-down enable is compared on every clock
// while SCL is high.
module tb_serial_mem_target;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 4;
    localparam int MEM_SIZE   = 4096;
    localparam int WATCHDOG   = 150000;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] SEL_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] SEL_R = {4'b1010, STRAP, 1'b1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_oe;
    logic        sda_bus;
    logic        bd_we = 1'b0;
    logic [11:0] bd_addr = '0;
    logic [7:0]  bd_data = '0;

    int    checks = 0;
    int    fails = 0;
    logic  exp_oe = 1'b0;
    string cur_req = "R3";
    bit    done = 1'b0;
    int    ref_mem [MEM_SIZE];
    int    ref_ctr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = !(m_low || sda_oe);

    serial_mem_target dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (m_scl),
        .sda_i   (sda_bus),
        .sda_oe  (sda_oe),
        .strap_i (STRAP),
        .bd_we   (bd_we),
        .bd_addr (bd_addr),
        .bd_data (bd_data)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 13) + ((i >> 8) * 5) + 7);
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison of the pull-down enable against the model (R3)
    always @(negedge clk) begin
        #1;
        if (rst_n && m_scl && !done) begin
            check(sda_oe == exp_oe, cur_req, "sda_oe while SCL high", int'(sda_oe), int'(exp_oe));
        end
    end

    task automatic wait_q(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic drive_low, output logic got);
        wait_q(QTR);
        m_low = drive_low;
        wait_q(QTR);
        m_scl = 1'b1;
        wait_q(QTR);
        got = sda_bus;
        wait_q(QTR);
        m_scl = 1'b0;
    endtask

    task automatic bus_start();
        exp_oe = 1'b0;
        if (!m_scl) begin
            wait_q(QTR);
            m_low = 1'b0;
            wait_q(QTR);
            m_scl = 1'b1;
        end
        wait_q(2*QTR);
        m_low = 1'b1;
        wait_q(2*QTR);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        exp_oe = 1'b0;
        wait_q(QTR);
        m_low = 1'b1;
        wait_q(QTR);
        m_scl = 1'b1;
        wait_q(2*QTR);
        m_low = 1'b0;
        wait_q(2*QTR);
    endtask

    task automatic send_byte(logic [7:0] b, bit want_ack, string req);
        logic got;
        cur_req = req;
        for (int i = 7; i >= 0; i--) begin
            exp_oe = 1'b0;
            bus_bit(!b[i], got);
        end
        exp_oe = want_ack;
        bus_bit(1'b0, got);
        check(got == !want_ack, req, "ack bit on bus", int'(got), int'(!want_ack));
        exp_oe = 1'b0;
    endtask

    task automatic recv_byte(bit master_ack, string req);
        logic [7:0] exp;
        logic [7:0] rx;
        logic       got;
        exp = 8'(ref_mem[ref_ctr]);
        cur_req = req;
        for (int i = 7; i >= 0; i--) begin
            exp_oe = !exp[i];
            bus_bit(1'b0, got);
            rx[i] = got;
        end
        check(rx == exp, req, $sformatf("byte from %0h", ref_ctr), int'(rx), int'(exp));
        ref_ctr = (ref_ctr + 1) % MEM_SIZE;
        exp_oe = 1'b0;
        cur_req = "R3";
        bus_bit(master_ack, got);
    endtask

    task automatic read_here(int n, string req);
        bus_start();
        send_byte(SEL_R, 1'b1, "R4");
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, req);
        end
        bus_stop();
    endtask

    task automatic read_at(logic [15:0] a, int n, string req);
        bus_start();
        send_byte(SEL_W, 1'b1, "R2");
        send_byte(a[15:8], 1'b1, "R5");
        send_byte(a[7:0], 1'b1, "R5");
        ref_ctr = int'(a[11:0]);
        bus_start();
        send_byte(SEL_R, 1'b1, "R5");
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, req);
        end
        bus_stop();
    endtask

    task automatic write_one(logic [15:0] a, logic [7:0] d);
        bus_start();
        send_byte(SEL_W, 1'b1, "R9");
        send_byte(a[15:8], 1'b1, "R9");
        send_byte(a[7:0], 1'b1, "R9");
        send_byte(d, 1'b1, "R9");
        bus_stop();
        ref_mem[a[11:0]] = int'(d);
        ref_ctr = (int'(a[11:0]) + 1) % MEM_SIZE;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R6 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic got;
        wait_q(5);
        rst_n = 1'b1;
        wait_q(2);
        // R1: released line after reset
        check(sda_oe == 1'b0, "R1", "sda_oe after reset", int'(sda_oe), 0);

        // R11: preload the whole array
        for (int i = 0; i < MEM_SIZE; i++) begin
            bd_we   = 1'b1;
            bd_addr = 12'(i);
            bd_data = pat(i);
            ref_mem[i] = int'(pat(i));
            @(negedge clk);
        end
        bd_we = 1'b0;
        wait_q(4);

        // R1, R4, R6, R11: counter starts at zero, two-byte burst
        read_here(2, "R1");

        // R5, R6: dummy write with junk upper bits, three-byte burst
        read_at(16'hFF3A, 3, "R6");

        // R8: resume at last location plus one
        read_here(1, "R8");

        // R2: wrong strap, no acknowledge anywhere, counter untouched
        bus_start();
        send_byte({4'b1010, 3'b010, 1'b0}, 1'b0, "R2");
        send_byte(8'h00, 1'b0, "R2");
        bus_stop();
        read_here(1, "R2");

        // R9: single-byte write, then counter at address plus one
        write_one(16'h0123, 8'h5A);
        read_here(1, "R9");
        read_at(16'h0123, 1, "R9");

        // R7: burst across the top of the array
        read_at(16'h0FFE, 4, "R7");

        // R10: repeated START inside the low address byte
        bus_start();
        send_byte(SEL_W, 1'b1, "R10");
        send_byte(8'h07, 1'b1, "R10");
        for (int i = 0; i < 4; i++) begin
            exp_oe = 1'b0;
            bus_bit(1'b0, got);
        end
        bus_start();
        send_byte(SEL_R, 1'b1, "R10");
        recv_byte(1'b0, "R10");
        bus_stop();

        // R10: STOP inside the data byte, nothing stored
        bus_start();
        send_byte(SEL_W, 1'b1, "R10");
        send_byte(8'h02, 1'b1, "R10");
        send_byte(8'h00, 1'b1, "R10");
        ref_ctr = 12'h200;
        for (int i = 0; i < 3; i++) begin
            exp_oe = 1'b0;
            bus_bit(1'b0, got);
        end
        bus_stop();
        read_here(1, "R10");

        done = 1'b1;
        wait_q(4);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule